// File: doc/BRIEF.md
# Eye-Opening Phase Selector

This block is the digital back end of a blind-oversampling clock and data recovery receiver. On every bit strobe it receives, for each of eight equally spaced sampling phases, the sliced data bit and two amplitude-window flags: one set when the sample lay above an upper reference level, and one set when it lay below a lower reference level. A sample is trusted only when it lies clearly outside the window between the two levels.

Over a fixed interval of bit strobes, the block keeps one tally per phase of trusted samples. At the end of the interval a majority vote picks the phase with the largest tally. Ties go to the lowest phase index. If no phase produced a single trusted sample, the previous choice stays in force. The recovered bit is always taken from the phase currently selected. The selection changes only at interval boundaries, and each boundary is marked by a one-cycle valid pulse. There is no tracking loop, so a fresh choice is ready after one interval. This suits burst reception.

Top module: `eye_phase_pick`

## Requirements
- R1: After synchronous reset, phase_sel is 4 (mid-bit), phase_vld is 0 and rx_bit is 0.
- R2: On a strobe, phase i counts as trusted only when exactly one of above_hi[i] and below_lo[i] is 1. Neither flag set (inside the window) or both set (inconsistent) counts as untrusted.
- R3: Tallies advance only on cycles with bit_stb high, and flag values on other cycles have no effect. A tally reaches at most INTERVAL (64 by default) without wrapping.
- R4: The INTERVAL-th strobe since reset or since the previous boundary ends an interval. From the next cycle, phase_sel (binary phase index 0..7) holds the phase with the largest tally, counting that final strobe.
- R5: When several phases share the largest tally, the lowest index among them is chosen.
- R6: When every tally is zero at a boundary, phase_sel keeps its previous value.
- R7: phase_vld is 1 for exactly the one cycle after each boundary strobe and 0 otherwise. phase_sel changes at no other time.
- R8: On each strobe, rx_bit is loaded with smp[phase_sel], using the phase_sel value present during that strobe cycle. It holds its value between strobes.
- R9: All tallies restart from zero after each boundary, so hits from an earlier interval carry no weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle strobe marking a new bit's samples |
| above_hi | input | 8 | Per-phase flag: sample above upper level |
| below_lo | input | 8 | Per-phase flag: sample below lower level |
| smp | input | 8 | Per-phase sliced data bit |
| rx_bit | output | 1 | Recovered data bit |
| phase_sel | output | 3 | Selected phase index |
| phase_vld | output | 1 | One-cycle pulse after each interval boundary |

## Verification
A corrupted tally or a bit counter that is off by one does not show up until the next boundary. It then appears at the ports as a wrong phase_sel or a phase_vld pulse at the wrong strobe, at most INTERVAL strobes later. From then on, every rx_bit is taken from the wrong phase. A fault in the data multiplexer shows on rx_bit one cycle after the first strobe it affects. The interval patterns are built so that each rule (the qualification rule, ignoring flags on non-strobe cycles, ties, the all-zero case, and clearing between intervals) gives a different winner when it is broken.

// File: rtl/eyesel_pkg.sv
package eyesel_pkg;
  localparam int unsigned PHASES        = 8;
  localparam int unsigned DEFAULT_PHASE = 4;

  // A sample is trusted only when it sits clearly on one side of the window
  function automatic logic qualify(input logic hi, input logic lo);
    return hi ^ lo;
  endfunction
endpackage

// File: rtl/eyesel_tally.sv
module eyesel_tally #(
  parameter int unsigned INTERVAL = 64,
  parameter int unsigned CW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          hit,
  input  logic          wrap,
  output logic [CW-1:0] cnt_fin
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (stb)  cnt_q <= wrap ? '0 : cnt_q + CW'(hit);
  end

  assign cnt_fin = cnt_q + CW'(hit);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(INTERVAL - 1)); // R3
  AST_TALLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/eyesel_vote.sv
module eyesel_vote #(
  parameter int unsigned NPH = 8,
  parameter int unsigned CW  = 7,
  parameter int unsigned PW  = 3
) (
  input  logic [NPH-1:0][CW-1:0] cnt,
  output logic [PW-1:0]          win,
  output logic                   any
);
  logic [CW-1:0] best;

  // strict greater-than keeps the lowest index on ties (R5)
  always_comb begin
    best = cnt[0];
    win  = '0;
    any  = (cnt[0] != '0);
    for (int i = 1; i < int'(NPH); i++) begin
      if (cnt[i] != '0) any = 1'b1;
      if (cnt[i] > best) begin
        best = cnt[i];
        win  = PW'(i);
      end
    end
  end
endmodule

// File: rtl/eye_phase_pick.sv
module eye_phase_pick #(
  parameter int unsigned NPH      = eyesel_pkg::PHASES,
  parameter int unsigned INTERVAL = 64,
  parameter int unsigned HOME     = eyesel_pkg::DEFAULT_PHASE,
  localparam int unsigned PW      = $clog2(NPH),
  localparam int unsigned CW      = $clog2(INTERVAL + 1),
  localparam int unsigned BW      = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_stb,
  input  logic [NPH-1:0] above_hi,
  input  logic [NPH-1:0] below_lo,
  input  logic [NPH-1:0] smp,
  output logic           rx_bit,
  output logic [PW-1:0]  phase_sel,
  output logic           phase_vld
);
  logic [NPH-1:0]          hit_w;
  logic [NPH-1:0][CW-1:0]  fin_w;
  logic [BW-1:0]           bit_q;
  logic                    bnd_w;
  logic [PW-1:0]           win_w;
  logic                    any_w;
  logic [PW-1:0]           sel_q;

  // interval position
  assign bnd_w = bit_stb && (bit_q == BW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst)          bit_q <= '0;
    else if (bit_stb) bit_q <= bnd_w ? '0 : bit_q + 1'b1;
  end

  // per-phase qualification and tallies
  for (genvar i = 0; i < int'(NPH); i++) begin : g_phase
    assign hit_w[i] = eyesel_pkg::qualify(above_hi[i], below_lo[i]);
    eyesel_tally #(.INTERVAL(INTERVAL), .CW(CW)) u_tally (
      .clk(clk), .rst(rst), .stb(bit_stb), .hit(hit_w[i]),
      .wrap(bnd_w), .cnt_fin(fin_w[i]));
  end

  eyesel_vote #(.NPH(NPH), .CW(CW), .PW(PW)) u_vote (
    .cnt(fin_w), .win(win_w), .any(any_w));

  // selection, boundary pulse and recovered data
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= PW'(HOME);
      phase_vld <= 1'b0;
      rx_bit    <= 1'b0;
    end else begin
      phase_vld <= bnd_w;
      if (bnd_w && any_w) sel_q <= win_w;
      if (bit_stb)        rx_bit <= smp[sel_q];
    end
  end

  assign phase_sel = sel_q;

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bnd_w |=> $stable(phase_sel)); // R7
  AST_VLD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    bnd_w |=> phase_vld); // R7
  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bnd_w |=> !phase_vld); // R7
  AST_KEEP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    bnd_w && !any_w |=> $stable(phase_sel)); // R6
  AST_RX_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(bit_stb) |-> rx_bit == $past(smp[sel_q])); // R8
endmodule

// File: tb/sim_eye_phase_pick.sv
module sim_eye_phase_pick;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_stb = 1'b0;
  logic [7:0] above_hi = '0, below_lo = '0, smp = '0;
  logic       rx_bit, phase_vld;
  logic [2:0] phase_sel;

  always #2 clk = ~clk;

  eye_phase_pick u0 (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .above_hi(above_hi),
    .below_lo(below_lo), .smp(smp), .rx_bit(rx_bit),
    .phase_sel(phase_sel), .phase_vld(phase_vld));

  typedef struct {
    logic       rx;
    logic [2:0] sel;
    logic       vld;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  logic [2:0] m_sel = 3'd4;
  int   m_cnt[8];
  int   m_bit = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: drives one strobe and pushes the expected outcome
  task automatic send_bit(input logic [7:0] ah, input logic [7:0] bl,
                          input logic [7:0] d, input string tag,
                          input int gap, input logic [7:0] gap_ah);
    exp_t e;
    int   bi;
    @(negedge clk);
    above_hi = ah; below_lo = bl; smp = d; bit_stb = 1'b1;
    e.rx = d[m_sel];
    for (int p = 0; p < 8; p++) m_cnt[p] += ((ah[p] != bl[p]) ? 1 : 0);
    m_bit++;
    e.vld = 1'b0;
    if (m_bit == 64) begin
      m_bit = 0;
      e.vld = 1'b1;
      bi = 0;
      for (int p = 1; p < 8; p++) if (m_cnt[p] > m_cnt[bi]) bi = p;
      if (m_cnt[bi] > 0) m_sel = 3'(bi);
      for (int p = 0; p < 8; p++) m_cnt[p] = 0;
    end
    e.sel = m_sel;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    bit_stb = 1'b0; above_hi = gap_ah; below_lo = '0;
    repeat (gap) @(negedge clk);
  endtask

  // monitor: compares each strobe's outcome once the registers settle
  always @(posedge clk) begin
    if (!rst && bit_stb) begin
      exp_t e;
      #1;
      if (q.size() == 0) chk("R8 queue", 0, 1);
      else begin
        e = q.pop_front();
        chk("R8 rx_bit", int'(rx_bit), int'(e.rx));
        chk({e.tag, " phase_sel"}, int'(phase_sel), int'(e.sel));
        chk("R7 phase_vld", int'(phase_vld), int'(e.vld));
      end
    end
  end

  task automatic run_interval(input int mode, input string tag);
    logic [7:0] ah, bl, d;
    for (int b = 0; b < 64; b++) begin
      ah = '0; bl = '0;
      d = 8'(b * 37 + mode * 11) ^ 8'h5A;
      case (mode)
        0: for (int k = 0; k < 8; k++)
             if (k == 6 || (b % 8) < k) begin
               if (b % 2 == 0) ah[k] = 1'b1; else bl[k] = 1'b1;
             end
        1: ah = 8'h24;
        3: begin
             ah[1] = 1'b1; bl[1] = 1'b1;
             if (b < 32) ah[3] = 1'b1; else bl[3] = 1'b1;
             ah[0] = (b < 32);
           end
        4: begin ah[5] = (b < 40); ah[0] = (b < 39); end
        6: ah[7] = (b < 10);
        7: bl[1] = (b < 5);
        8: ah = 8'hFF;
        default: ;
      endcase
      send_bit(ah, bl, d, tag, (mode == 4) ? 2 : 0, (mode == 4) ? 8'h01 : 8'h00);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 phase_sel", int'(phase_sel), 4);
    chk("R1 phase_vld", int'(phase_vld), 0);
    chk("R1 rx_bit", int'(rx_bit), 0);
    run_interval(0, "R4");  // phase 6 strongest
    run_interval(1, "R5");  // tie between 2 and 5
    run_interval(2, "R6");  // nothing trusted, keep 2
    run_interval(3, "R2");  // both-flags phase ignored, 3 wins
    run_interval(4, "R3");  // idle-cycle flags must not count, 5 wins
    run_interval(6, "R4");  // 7 wins
    run_interval(7, "R9");  // fresh tallies, 1 wins
    run_interval(8, "R3");  // full tallies, tie at maximum, 0 wins
    repeat (3) @(negedge clk);
    chk("R7 pending items", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule